// File: doc/BRIEF.md
# Receive Elastic Buffer with Programmable Launch Offset

This block sits between two clock domains in a line receiver. On the line side, a recovered bit clock writes payload bytes into the buffer. An upstream stage has already removed overhead, sync and stuff bits, so this side never writes during those bits. On the PCM side, a bit clock takes one 8-bit timeslot out of the buffer every eight PCM bit periods, and the block marks the start of each internal PCM frame. Read and write pointers cross between the domains in Gray code through two-flop synchronizers.

The phase offset between the master line frame start and the internal PCM frame sync is set once, when software issues a receiver reset command. The command clears both pointers and both sticky flags, then holds the PCM side idle. Writes are accepted while the PCM side is idle, so the buffer fills ahead of the reader. The next master frame start arms a delay counter that runs on line bit clocks. When the counter reaches the programmed water level, the PCM side is released. After release the offset is free to drift. Later frame starts have no effect until the next command.

Fill is measured in bits and is capped by the smallest of three limits: the PCM bits mapped per frame, a fixed maximum of 185 bits, and the payload block length. A write that would exceed the cap is dropped and flagged. A timeslot that finds no byte in the buffer is filled with ones and flagged.

Top module: `rx_elastic_fifo`

## Requirements
- R1: After reset, `ovf_flag`, `udf_flag`, `ts_valid`, `pcm_sync` and `rx_launch` are all 0.
- R2: Every accepted byte comes out on `ts_data` with `ts_fill` = 0, exactly once, in the order it was written.
- R3: A write is accepted only if (stored bytes + 1) × 8 is no more than the effective limit. A write that fails this test is dropped and sets `ovf_flag`, which stays set until the next receiver reset command.
- R4: The effective limit is the minimum of `map_bits`, `blk_bits` and 185. With large settings the buffer therefore holds at most 23 bytes.
- R5: A timeslot that finds no stored byte has `ts_fill` = 1 and `ts_data` = 8'hFF, and it sets `udf_flag`. That flag is sticky until the next receiver reset command.
- R6: After a command, `rx_launch` goes high exactly `wl_cfg` line clock cycles after the first `line_fs` cycle, counting the `line_fs` cycle as cycle 0. With `wl_cfg` = 0, it is high in the `line_fs` cycle itself.
- R7: Once launched, `ts_valid` pulses every 8 PCM clock cycles and `pcm_sync` pulses every 192 PCM clock cycles (the PCM frame length parameter).
- R8: A `line_fs` that arrives after launch produces no further `rx_launch`.
- R9: `rx_rst_cmd` clears both flags and discards all stored bytes. The first byte read afterwards is the first byte accepted after the command.
- R10: From a command until launch, the PCM side produces no timeslots, while line-side writes are still accepted up to the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Recovered line bit clock |
| rrst | input | 1 | Synchronous active-high reset, line domain |
| pclk | input | 1 | PCM bit clock |
| prst | input | 1 | Synchronous active-high reset, PCM domain |
| rx_rst_cmd | input | 1 | Receiver reset command pulse (line domain) |
| line_fs | input | 1 | Master line channel 6 ms frame start |
| wl_cfg | input | 8 | Water level in line bit delays |
| map_bits | input | 9 | PCM bits mapped per PCM frame |
| blk_bits | input | 9 | Payload block length in bits |
| wr_valid | input | 1 | Payload byte strobe |
| wr_byte | input | 8 | Payload byte |
| ovf_flag | output | 1 | Sticky overflow flag (line domain) |
| rx_launch | output | 1 | PCM sync launch strobe (line domain) |
| ts_valid | output | 1 | Timeslot strobe (PCM domain) |
| ts_data | output | 8 | Timeslot byte |
| ts_fill | output | 1 | Timeslot is filler, not stored data |
| udf_flag | output | 1 | Sticky underflow flag (PCM domain) |
| pcm_sync | output | 1 | Internal PCM frame sync pulse |

## Verification
The bench measures the launch delay at a water level of 0, at a small value, and at 200. A counter that is off by one, or that launches only on the following bit, shows up as a wrong cycle count. It fills the buffer to each of the three limits in turn. A design that took the wrong minimum, or compared against the limit off by one byte, would accept one byte too many or too few, and the scoreboard reports the mismatch in byte count and order. After a command it leaves stale bytes in the buffer. A design that failed to clear its pointers would then return the old bytes ahead of the new ones. It also drains the buffer empty, to check the all-ones filler and the sticky underflow flag, and sends a late frame start, which must not trigger a relaunch.

// File: rtl/rxe_pkg.sv
package rxe_pkg;

    localparam int BYTE_W = 8;
    localparam int LIM_W  = 9;
    localparam logic [BYTE_W-1:0] FILL_BYTE = '1;

    typedef enum logic [1:0] {
        WL_WAIT_ACK,
        WL_ARMED,
        WL_COUNT,
        WL_RUN
    } wl_state_e;

    typedef struct packed {
        logic              fill;
        logic [BYTE_W-1:0] data;
    } slot_t;

    function automatic logic [LIM_W-1:0] lim_min3(
        input logic [LIM_W-1:0] a,
        input logic [LIM_W-1:0] b,
        input logic [LIM_W-1:0] c
    );
        logic [LIM_W-1:0] m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

endpackage

// File: rtl/rxe_sync2.sv
module rxe_sync2 #(
    parameter int          W       = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= {W{RST_VAL}};
            q    <= {W{RST_VAL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rxe_wr.sv
module rxe_wr
    import rxe_pkg::*;
#(
    parameter int AW   = 5,
    parameter int WL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd,
    input  logic              line_fs,
    input  logic [WL_W-1:0]   wl_cfg,
    input  logic [LIM_W-1:0]  lim,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [AW:0]       rgray_s,
    input  logic              ack_s,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [AW:0]       wgray,
    output logic              hold,
    output logic              ovf,
    output logic              launch
);
    localparam int PW = AW + 1;
    localparam int CW = ((LIM_W > PW + 3) ? LIM_W : PW + 3) + 1;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wl_state_e       state;
    logic [WL_W-1:0] cnt, wl_q;
    logic [PW-1:0]   wptr, wnext, rptr_b, occ;
    logic [CW-1:0]   occ_bits, need_bits;
    logic            open, room_ok, try_wr, accept;

    always_comb begin
        rptr_b    = g2b(rgray_s);
        occ       = wptr - rptr_b;
        occ_bits  = CW'({occ, 3'b000});
        need_bits = occ_bits + CW'(BYTE_W);
        room_ok   = need_bits <= CW'(lim);
        open      = (state != WL_WAIT_ACK);
        try_wr    = wr_valid && open && !cmd;
        accept    = try_wr && room_ok;
        wnext     = wptr + 1'b1;
        launch    = !cmd && (((state == WL_ARMED) && line_fs && (wl_cfg == '0)) ||
                             ((state == WL_COUNT) && (cnt == wl_q)));
    end

    assign mem_we    = accept;
    assign mem_waddr = wptr[AW-1:0];
    assign mem_wdata = wr_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WL_WAIT_ACK;
            wptr  <= '0;
            wgray <= '0;
            ovf   <= 1'b0;
            hold  <= 1'b1;
            cnt   <= '0;
            wl_q  <= '0;
        end else if (cmd) begin
            state <= WL_WAIT_ACK;
            ovf   <= 1'b0;
            hold  <= 1'b1;
        end else begin
            if (accept) begin
                wptr  <= wnext;
                wgray <= wnext ^ (wnext >> 1);
            end
            if (try_wr && !room_ok) ovf <= 1'b1;
            if (launch) hold <= 1'b0;
            case (state)
                WL_WAIT_ACK: if (ack_s) begin
                    state <= WL_ARMED;
                    wptr  <= '0;
                    wgray <= '0;
                end
                WL_ARMED: if (line_fs) begin
                    if (wl_cfg == '0) state <= WL_RUN;
                    else begin
                        state <= WL_COUNT;
                        cnt   <= WL_W'(1);
                        wl_q  <= wl_cfg;
                    end
                end
                WL_COUNT: if (cnt == wl_q) state <= WL_RUN;
                          else cnt <= cnt + 1'b1;
                default: ;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        open |-> (occ_bits <= CW'(lim)));

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf && !cmd) |=> ovf);

    assert_rptr_gray_R2: assert property (@(posedge clk) disable iff (rst)
        ((state == WL_RUN) && ($past(state) == WL_RUN)) |->
        ($countones(rgray_s ^ $past(rgray_s)) <= 1));
endmodule

// File: rtl/rxe_rd.sv
module rxe_rd
    import rxe_pkg::*;
#(
    parameter int AW         = 5,
    parameter int FRAME_BITS = 192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_s,
    input  logic [AW:0]       wgray_s,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [AW-1:0]     mem_raddr,
    output logic [AW:0]       rgray,
    output logic              idle,
    output logic              ts_valid,
    output slot_t             slot,
    output logic              udf,
    output logic              pcm_sync
);
    localparam int PW = AW + 1;
    localparam int FW = $clog2(FRAME_BITS);

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PW-1:0] rptr, rnext, wptr_b;
    logic [2:0]    bitcnt;
    logic [FW-1:0] fbit;
    logic          empty, slot_start;

    always_comb begin
        wptr_b     = g2b(wgray_s);
        empty      = (wptr_b == rptr);
        rnext      = rptr + 1'b1;
        slot_start = (bitcnt == 3'd0);
    end

    assign mem_raddr = rptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst || hold_s) begin
            idle     <= 1'b1;
            rptr     <= '0;
            rgray    <= '0;
            udf      <= 1'b0;
            bitcnt   <= '0;
            fbit     <= '0;
            ts_valid <= 1'b0;
            slot     <= '{fill: 1'b0, data: '0};
            pcm_sync <= 1'b0;
        end else begin
            idle     <= 1'b0;
            ts_valid <= slot_start;
            pcm_sync <= (fbit == '0);
            bitcnt   <= bitcnt + 1'b1;
            fbit     <= (fbit == FW'(FRAME_BITS - 1)) ? '0 : fbit + 1'b1;
            if (slot_start) begin
                if (empty) begin
                    slot <= '{fill: 1'b1, data: FILL_BYTE};
                    udf  <= 1'b1;
                end else begin
                    slot  <= '{fill: 1'b0, data: mem_rdata};
                    rptr  <= rnext;
                    rgray <= rnext ^ (rnext >> 1);
                end
            end
        end
    end

    assert_udf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (udf && !hold_s) |=> udf);

    assert_slot_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        ts_valid |=> !ts_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (idle && $past(idle)) |-> !ts_valid);

    assert_wptr_gray_R2: assert property (@(posedge clk) disable iff (rst)
        (!idle && !$past(idle)) |-> ($countones(wgray_s ^ $past(wgray_s)) <= 1));
endmodule

// File: rtl/rx_elastic_fifo.sv
module rx_elastic_fifo
    import rxe_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int MAX_BITS   = 185,
    parameter int FRAME_BITS = 192,
    parameter int WL_W       = 8
) (
    input  logic              rclk,
    input  logic              rrst,
    input  logic              pclk,
    input  logic              prst,
    input  logic              rx_rst_cmd,
    input  logic              line_fs,
    input  logic [WL_W-1:0]   wl_cfg,
    input  logic [LIM_W-1:0]  map_bits,
    input  logic [LIM_W-1:0]  blk_bits,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              ovf_flag,
    output logic              rx_launch,
    output logic              ts_valid,
    output logic [BYTE_W-1:0] ts_data,
    output logic              ts_fill,
    output logic              udf_flag,
    output logic              pcm_sync
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    logic [BYTE_W-1:0] mem_wdata;
    logic [PW-1:0]     wgray, wgray_s, rgray, rgray_s;
    logic              hold, hold_s, idle, ack_s;
    logic [LIM_W-1:0]  lim;
    slot_t             slot;

    assign lim = lim_min3(map_bits, blk_bits, LIM_W'(MAX_BITS));

    always_ff @(posedge rclk) begin
        if (mem_we) mem[mem_waddr] <= mem_wdata;
    end

    rxe_wr #(.AW(AW), .WL_W(WL_W)) u_wr (
        .clk(rclk), .rst(rrst), .cmd(rx_rst_cmd), .line_fs(line_fs),
        .wl_cfg(wl_cfg), .lim(lim), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .rgray_s(rgray_s), .ack_s(ack_s), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wgray(wgray),
        .hold(hold), .ovf(ovf_flag), .launch(rx_launch)
    );

    rxe_sync2 #(.W(PW), .RST_VAL(1'b0)) u_wsync (
        .clk(pclk), .rst(prst), .d(wgray), .q(wgray_s));
    rxe_sync2 #(.W(1), .RST_VAL(1'b1)) u_hsync (
        .clk(pclk), .rst(prst), .d(hold), .q(hold_s));
    rxe_sync2 #(.W(PW), .RST_VAL(1'b0)) u_rsync (
        .clk(rclk), .rst(rrst), .d(rgray), .q(rgray_s));
    rxe_sync2 #(.W(1), .RST_VAL(1'b0)) u_async (
        .clk(rclk), .rst(rrst), .d(idle), .q(ack_s));

    rxe_rd #(.AW(AW), .FRAME_BITS(FRAME_BITS)) u_rd (
        .clk(pclk), .rst(prst), .hold_s(hold_s), .wgray_s(wgray_s),
        .mem_rdata(mem[mem_raddr]), .mem_raddr(mem_raddr), .rgray(rgray),
        .idle(idle), .ts_valid(ts_valid), .slot(slot), .udf(udf_flag),
        .pcm_sync(pcm_sync)
    );

    assign ts_data = slot.data;
    assign ts_fill = slot.fill;
endmodule

// File: tb/rx_elastic_fifo_tb.sv
module rx_elastic_fifo_tb;
    localparam int CLK_PERIOD  = 10;
    localparam int PCLK_PERIOD = 11;
    localparam int FRAME       = 192;

    logic       rclk = 0, pclk = 0, rrst = 1, prst = 1;
    logic       rx_rst_cmd = 0, line_fs = 0, wr_valid = 0;
    logic [7:0] wl_cfg = 0, wr_byte = 0;
    logic [8:0] map_bits = 9'd192, blk_bits = 9'd400;
    logic       ovf_flag, rx_launch, ts_valid, ts_fill, udf_flag, pcm_sync;
    logic [7:0] ts_data;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    bit idle_expected = 0;
    bit done = 0;
    longint pcyc = 0, last_ts = 0, last_sync = 0;
    int fill_seen = 0;

    always #(CLK_PERIOD/2)  rclk = ~rclk;
    always #(PCLK_PERIOD/2.0) pclk = ~pclk;

    rx_elastic_fifo u_dut (
        .rclk(rclk), .rrst(rrst), .pclk(pclk), .prst(prst),
        .rx_rst_cmd(rx_rst_cmd), .line_fs(line_fs), .wl_cfg(wl_cfg),
        .map_bits(map_bits), .blk_bits(blk_bits), .wr_valid(wr_valid),
        .wr_byte(wr_byte), .ovf_flag(ovf_flag), .rx_launch(rx_launch),
        .ts_valid(ts_valid), .ts_data(ts_data), .ts_fill(ts_fill),
        .udf_flag(udf_flag), .pcm_sync(pcm_sync)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor on the PCM side
    always @(negedge pclk) begin
        pcyc++;
        if (ts_valid) begin
            if (idle_expected) chk(0, "R10 slot while idle", 1, 0);
            if (last_ts != 0) chk(pcyc - last_ts == 8, "R7 slot spacing", pcyc - last_ts, 8);
            last_ts = pcyc;
            if (ts_fill) begin
                fill_seen++;
                chk(ts_data == 8'hFF, "R5 filler byte", ts_data, 8'hFF);
                if (exp_q.size() != 0) chk(0, "R2 filler while data pending", exp_q.size(), 0);
            end else if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected byte", ts_data, -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(ts_data == e, "R2 byte order", ts_data, e);
            end
        end
        if (pcm_sync) begin
            if (last_sync != 0) chk(pcyc - last_sync == FRAME, "R7 frame sync period", pcyc - last_sync, FRAME);
            last_sync = pcyc;
        end
    end

    task automatic wr_one(input logic [7:0] b, input bit push);
        @(negedge rclk);
        wr_valid = 1; wr_byte = b;
        if (push) exp_q.push_back(b);
        @(negedge rclk);
        wr_valid = 0;
        repeat (6) @(negedge rclk);
    endtask

    task automatic issue_cmd();
        @(negedge rclk); rx_rst_cmd = 1;
        @(negedge rclk); rx_rst_cmd = 0;
        repeat (15) @(negedge rclk);
        exp_q.delete();
        idle_expected = 1;
    endtask

    task automatic fs_launch(input logic [7:0] wl, input string req);
        int n;
        wl_cfg = wl;
        @(negedge rclk);
        idle_expected = 0; last_ts = 0; last_sync = 0;
        line_fs = 1;
        #1 n = rx_launch ? 0 : -1;
        for (int i = 1; i <= 300 && n < 0; i++) begin
            @(negedge rclk); line_fs = 0;
            #1 if (rx_launch) n = i;
        end
        @(negedge rclk); line_fs = 0;
        chk(n == wl, req, n, wl);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        repeat (40) @(negedge pclk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(0, "watchdog expired", 0, 1);
        finish_sim();
    end

    initial begin
        repeat (6) @(negedge rclk);
        rrst = 0; prst = 0;
        @(negedge rclk); #1;
        chk(!ovf_flag && !udf_flag && !ts_valid && !pcm_sync && !rx_launch, "R1 reset state",
            {ovf_flag, udf_flag, ts_valid, pcm_sync, rx_launch}, 0);
        repeat (15) @(negedge rclk);
        idle_expected = 1;

        // prefill while idle (R10), launch at wl=5 (R6), stream (R2, R7)
        for (int i = 0; i < 4; i++) wr_one(8'h10 + 8'(i), 1);
        chk(!ovf_flag, "R10 prefill accepted", ovf_flag, 0);
        fs_launch(8'd5, "R6 launch delay wl=5");
        for (int i = 0; i < 36; i++) wr_one(8'hA0 ^ 8'(i * 7), 1);
        drain();
        chk(udf_flag == 1, "R5 underflow flag sticky", udf_flag, 1);
        chk(fill_seen > 0, "R5 filler slots seen", fill_seen, 1);
        chk(last_sync != 0, "R7 frame sync seen", last_sync, 1);

        // late frame start must not relaunch (R8)
        begin
            int extra = 0;
            @(negedge rclk); line_fs = 1;
            #1 if (rx_launch) extra++;
            for (int i = 0; i < 300; i++) begin
                @(negedge rclk); line_fs = 0;
                #1 if (rx_launch) extra++;
            end
            chk(extra == 0, "R8 no relaunch", extra, 0);
        end

        // block-length limit 40 bits -> 5 bytes (R3, R4), clears flags (R9)
        issue_cmd();
        chk(!ovf_flag && !udf_flag, "R9 flags cleared", {ovf_flag, udf_flag}, 0);
        blk_bits = 9'd40;
        for (int i = 0; i < 5; i++) wr_one(8'h30 + 8'(i), 1);
        chk(!ovf_flag, "R3 limit not yet reached", ovf_flag, 0);
        wr_one(8'hEE, 0);
        wr_one(8'hEF, 0);
        chk(ovf_flag, "R3 overflow flag set", ovf_flag, 1);
        fs_launch(8'd0, "R6 launch delay wl=0");
        drain();
        chk(ovf_flag, "R3 overflow flag sticky", ovf_flag, 1);
        chk(exp_q.size() == 0, "R3 accepted byte count", exp_q.size(), 0);

        // mapped-bits limit 24 -> 3 bytes (R4), left stale
        issue_cmd();
        chk(!ovf_flag && !udf_flag, "R9 flags cleared again", {ovf_flag, udf_flag}, 0);
        blk_bits = 9'd400; map_bits = 9'd24;
        for (int i = 0; i < 3; i++) wr_one(8'h5A, 0);
        chk(!ovf_flag, "R4 map limit not yet reached", ovf_flag, 0);
        wr_one(8'h5B, 0);
        chk(ovf_flag, "R4 map limit overflow", ovf_flag, 1);

        // stale bytes discarded (R9), fixed 185-bit cap -> 23 bytes (R4)
        issue_cmd();
        chk(!ovf_flag, "R9 overflow cleared", ovf_flag, 0);
        map_bits = 9'd192;
        for (int i = 0; i < 23; i++) wr_one(8'hC0 + 8'(i), 1);
        chk(!ovf_flag, "R4 23 bytes fit under 185", ovf_flag, 0);
        wr_one(8'h77, 0);
        wr_one(8'h78, 0);
        chk(ovf_flag, "R4 24th byte exceeds 185", ovf_flag, 1);
        fs_launch(8'd200, "R6 launch delay wl=200");
        drain();
        chk(exp_q.size() == 0, "R9 only new bytes read", exp_q.size(), 0);

        finish_sim();
    end
endmodule